// File: doc/BRIEF.md
# Priority Input Clock Selector

This block picks one reference out of a set of candidate clock inputs for a synchronizer loop. Each candidate comes with a qualification bit, produced elsewhere, and a programmable priority value. The block combines these with four external loss-of-signal pins. Each input can be tied to any subset of those pins, and a raised pin removes every input tied to it. From the inputs that remain usable, the block finds the one with the best priority. It then reports two indices: the input it currently routes and the best usable input.

The block has two switching modes. In revertive mode the routed input always follows the best usable input. In non-revertive mode the routed input is kept for as long as it stays usable. A new choice is made only after it drops out. When nothing is usable, the routed index freezes and a no-reference flag is raised. Both indices and the flag are registered. A change on the qualification bits, the priorities or the loss pins shows on the outputs after one clock edge. A change in the pin association shows after two edges.

Top module: `prio_clk_selector`

## Requirements
- R1: In revertive mode (`revert_en`=1), `sel_idx` becomes the index of the best usable input on the first clock edge after that input becomes usable, and moves back when it stops being usable.
- R2: In non-revertive mode (`revert_en`=0), an input with better priority that becomes usable does not change `sel_idx` while the current selection stays usable.
- R3: In non-revertive mode, when the current selection stops being usable, `sel_idx` moves to the best usable input on the next edge. A selection is always an input that was usable on the edge that set or kept it.
- R4: `best_idx` reports the best usable input. In revertive mode, `sel_idx` equals `best_idx` whenever `no_ref` is 0.
- R5: Priority value 0 makes an input unusable. Among nonzero values, a smaller value is better. Equal values are resolved in favour of the lower input index.
- R6: Bit `i*4+j` of `los_map` ties input `i` to `los_pin[j]`. A high tied pin makes that input unusable. An untied pin has no effect on it. A change to `los_map` takes effect after two clock edges, and a change to the pins after one.
- R7: Reset gives `sel_idx`=0, `best_idx`=0, `no_ref`=1, and clears the internal pin association, so that no input is tied to any pin.
- R8: When no input is usable, `no_ref` is 1 on the next edge, and `sel_idx` and `best_idx` keep their last values.
- R9: `sel_idx` only changes directly to the value that `best_idx` takes on the same edge, never through another index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| revert_en | input | 1 | 1 = revertive, 0 = non-revertive |
| in_qual | input | N_IN | Qualification bit per input |
| prio_cfg | input | N_IN*PRIO_W | Priority per input, input i in bits [i*PRIO_W +: PRIO_W] |
| los_pin | input | N_LOS | External loss-of-signal pins, active high |
| los_map | input | N_IN*N_LOS | Association of each input with each pin |
| sel_idx | output | IDX_W | Index of the routed input |
| best_idx | output | IDX_W | Index of the best usable input |
| no_ref | output | 1 | No input is usable |

## Verification
Two things can land on the same edge: a raised loss pin, or a disqualification, that removes the current selection, and the choice of the next best input. The bench provokes this by raising a pin tied to the routed input while a lower-priority input is still qualified. It then checks that the selection jumps to that input in a single edge. The bench also ties both remaining inputs to pins at the same time and checks that `no_ref` rises while `sel_idx` freezes. The bound checker judges every edge for a direct jump to `best_idx`, for a frozen index under `no_ref`, and for a routed input that was usable one cycle earlier.

// File: rtl/pis_pkg.sv
package pis_pkg;
  typedef enum logic {
    MODE_HOLD   = 1'b0,
    MODE_REVERT = 1'b1
  } sel_mode_e;

  // True when a candidate priority beats the best one found so far.
  // Strictly smaller wins, so an equal value keeps the earlier (lower) index.
  function automatic logic prio_beats(input int unsigned cand,
                                      input int unsigned best,
                                      input logic have_best);
    return (!have_best) || (cand < best);
  endfunction
endpackage

// File: rtl/pis_los_gate.sv
module pis_los_gate #(
  parameter int N_IN   = 14,
  parameter int N_LOS  = 4,
  parameter int PRIO_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_qual,
  input  logic [N_IN*PRIO_W-1:0]  prio_cfg,
  input  logic [N_LOS-1:0]        los_pin,
  input  logic [N_IN*N_LOS-1:0]   los_map,
  output logic [N_IN-1:0]         los_hit,
  output logic [N_IN-1:0]         elig
);
  logic [N_IN*N_LOS-1:0] map_q;

  // Association register: cleared by reset so no pin touches any input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= los_map;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    logic [N_LOS-1:0]  tie;
    logic [PRIO_W-1:0] pv;
    assign tie        = map_q[i*N_LOS +: N_LOS];
    assign pv         = prio_cfg[i*PRIO_W +: PRIO_W];
    assign los_hit[i] = |(tie & los_pin);
    assign elig[i]    = in_qual[i] && !los_hit[i] && (pv != '0);
  end
endmodule

// File: rtl/pis_prio_search.sv
module pis_prio_search
  import pis_pkg::*;
#(
  parameter int N_IN   = 14,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic [N_IN-1:0]        elig,
  input  logic [N_IN*PRIO_W-1:0] prio_cfg,
  output logic [IDX_W-1:0]       win_idx,
  output logic                   any_elig
);
  always_comb begin
    int unsigned best_p;
    win_idx  = '0;
    any_elig = 1'b0;
    best_p   = 0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig[i] &&
          prio_beats(int'(prio_cfg[i*PRIO_W +: PRIO_W]), best_p, any_elig)) begin
        win_idx  = IDX_W'(i);
        best_p   = int'(prio_cfg[i*PRIO_W +: PRIO_W]);
        any_elig = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pis_sel_ctrl.sv
module pis_sel_ctrl
  import pis_pkg::*;
#(
  parameter int N_IN  = 14,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             revert_en,
  input  logic [N_IN-1:0]  elig,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             any_elig,
  output logic [IDX_W-1:0] sel_idx,
  output logic [IDX_W-1:0] best_idx,
  output logic             no_ref,
  output logic             cur_ok
);
  localparam int PAD_W = 2 ** IDX_W;

  sel_mode_e        mode;
  logic [PAD_W-1:0] elig_pad;
  logic             locked_q;
  logic             take_win;

  assign mode     = sel_mode_e'(revert_en);
  assign elig_pad = PAD_W'(elig);
  assign cur_ok   = locked_q && elig_pad[sel_idx];

  always_comb begin
    take_win = 1'b0;
    if (any_elig) begin
      if (mode == MODE_REVERT) take_win = 1'b1;
      else                     take_win = !cur_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      best_idx <= '0;
      no_ref   <= 1'b1;
      locked_q <= 1'b0;
    end else begin
      no_ref   <= !any_elig;
      locked_q <= any_elig;
      if (any_elig) best_idx <= win_idx;
      if (take_win) sel_idx  <= win_idx;
    end
  end
endmodule

// File: rtl/prio_clk_selector.sv
module prio_clk_selector #(
  parameter int N_IN   = 14,
  parameter int N_LOS  = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   revert_en,
  input  logic [N_IN-1:0]        in_qual,
  input  logic [N_IN*PRIO_W-1:0] prio_cfg,
  input  logic [N_LOS-1:0]       los_pin,
  input  logic [N_IN*N_LOS-1:0]  los_map,
  output logic [IDX_W-1:0]       sel_idx,
  output logic [IDX_W-1:0]       best_idx,
  output logic                   no_ref
);
  logic [N_IN-1:0]  los_hit_w;
  logic [N_IN-1:0]  elig_w;
  logic [IDX_W-1:0] win_idx_w;
  logic             any_elig_w;
  logic             cur_ok_w;

  pis_los_gate #(.N_IN(N_IN), .N_LOS(N_LOS), .PRIO_W(PRIO_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_qual  (in_qual),
    .prio_cfg (prio_cfg),
    .los_pin  (los_pin),
    .los_map  (los_map),
    .los_hit  (los_hit_w),
    .elig     (elig_w)
  );

  pis_prio_search #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_search (
    .elig     (elig_w),
    .prio_cfg (prio_cfg),
    .win_idx  (win_idx_w),
    .any_elig (any_elig_w)
  );

  pis_sel_ctrl #(.N_IN(N_IN), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .revert_en (revert_en),
    .elig      (elig_w),
    .win_idx   (win_idx_w),
    .any_elig  (any_elig_w),
    .sel_idx   (sel_idx),
    .best_idx  (best_idx),
    .no_ref    (no_ref),
    .cur_ok    (cur_ok_w)
  );
endmodule

// File: rtl/pis_sel_checker.sv
module pis_sel_checker #(
  parameter int N_IN  = 14,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             revert_en,
  input logic [N_IN-1:0]  elig,
  input logic             cur_ok,
  input logic [IDX_W-1:0] sel_idx,
  input logic [IDX_W-1:0] best_idx,
  input logic             no_ref
);
  // R4
  revert_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(revert_en) && !no_ref) |-> (sel_idx == best_idx));

  // R2
  hold_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(revert_en) && $past(cur_ok)) |-> $stable(sel_idx));

  // R8
  noref_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_ref |-> ($stable(sel_idx) && $stable(best_idx)));

  // R9
  direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx != $past(sel_idx)) |-> (sel_idx == best_idx));

  // R3
  sel_usable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !no_ref |-> ((($past(elig) >> sel_idx) & N_IN'(1)) != '0));
endmodule

bind prio_clk_selector pis_sel_checker #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .revert_en (revert_en),
  .elig      (elig_w),
  .cur_ok    (cur_ok_w),
  .sel_idx   (sel_idx),
  .best_idx  (best_idx),
  .no_ref    (no_ref)
);

// File: tb/prio_clk_selector_tb.sv
`timescale 1ns/1ps
module prio_clk_selector_tb;
  localparam int N  = 14;
  localparam int NL = 4;
  localparam int PW = 4;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            revert_en = 1'b1;
  logic [N-1:0]    in_qual = '0;
  logic [N*PW-1:0] prio_cfg = '0;
  logic [NL-1:0]   los_pin = '0;
  logic [N*NL-1:0] los_map = '0;
  logic [IW-1:0]   sel_idx, best_idx;
  logic            no_ref;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_clk_selector #(.N_IN(N), .N_LOS(NL), .PRIO_W(PW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .revert_en(revert_en), .in_qual(in_qual),
    .prio_cfg(prio_cfg), .los_pin(los_pin), .los_map(los_map),
    .sel_idx(sel_idx), .best_idx(best_idx), .no_ref(no_ref)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_prio(input int idx, input int val);
    prio_cfg[idx*PW +: PW] = PW'(val);
  endtask

  task automatic default_prio();
    for (int i = 0; i < N; i++) set_prio(i, i + 1);
  endtask

  task automatic only(input int a, input int b);
    in_qual = '0;
    if (a >= 0) in_qual[a] = 1'b1;
    if (b >= 0) in_qual[b] = 1'b1;
  endtask

  task automatic t_reset();
    default_prio();
    revert_en = 1'b1;
    only(0, -1);
    los_map[0*NL + 0] = 1'b1;
    los_pin = 4'b0001;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R7", "sel after reset", sel_idx, 0);
    chk("R7", "best after reset", best_idx, 0);
    chk("R7", "no_ref after reset", no_ref, 1);
    step();  // association register was clear on this edge
    chk("R7", "no_ref with cleared map", no_ref, 0);
    chk("R7", "sel with cleared map", sel_idx, 0);
    step();  // association now loaded: input 0 tied to high pin
    chk("R6", "no_ref after map latency", no_ref, 1);
    los_map = '0;
    los_pin = '0;
    step(); step();
  endtask

  task automatic t_revert();
    revert_en = 1'b1;
    only(5, -1);
    step();
    chk("R1", "sel single input", sel_idx, 5);
    only(5, 2);
    step();
    chk("R1", "sel moves to better", sel_idx, 2);
    chk("R4", "best tracks", best_idx, 2);
    only(5, -1);
    step();
    chk("R1", "sel moves back", sel_idx, 5);
  endtask

  task automatic t_hold();
    revert_en = 1'b0;
    only(5, 2);
    step();
    chk("R2", "sel held", sel_idx, 5);
    chk("R4", "best still reported", best_idx, 2);
    step();
    chk("R2", "sel still held", sel_idx, 5);
    only(2, -1);
    step();
    chk("R3", "reselect after loss", sel_idx, 2);
    chk("R9", "jump lands on best", best_idx, 2);
  endtask

  task automatic t_prio();
    revert_en = 1'b1;
    set_prio(3, 0);
    only(3, 9);
    step();
    chk("R5", "zero priority excluded", sel_idx, 9);
    only(3, -1);
    step();
    chk("R5", "zero priority alone gives no_ref", no_ref, 1);
    set_prio(7, 10);  // same value as input 9
    only(7, 9);
    step();
    chk("R5", "tie resolved to lower index", sel_idx, 7);
    set_prio(9, 2);   // input 9 now better than input 7
    step();
    chk("R5", "smaller value wins", sel_idx, 9);
    default_prio();
    step();
  endtask

  task automatic t_noref();
    revert_en = 1'b1;
    only(6, -1);
    step();
    chk("R8", "sel before loss", sel_idx, 6);
    only(-1, -1);
    step();
    chk("R8", "no_ref raised", no_ref, 1);
    chk("R8", "sel frozen", sel_idx, 6);
    chk("R8", "best frozen", best_idx, 6);
    only(8, -1);
    step();
    chk("R8", "recovery", sel_idx, 8);
    chk("R8", "no_ref cleared", no_ref, 0);
  endtask

  task automatic t_los();
    revert_en = 1'b1;
    only(8, 11);
    los_map[8*NL + 2] = 1'b1;
    step(); step();
    chk("R6", "sel before pin", sel_idx, 8);
    los_pin = 4'b0100;
    step();
    chk("R6", "tied pin drops input", sel_idx, 11);
    los_pin = 4'b0110;
    step();
    chk("R6", "untied pin no effect", sel_idx, 11);
    chk("R6", "untied pin no_ref", no_ref, 0);
    los_map[11*NL + 1] = 1'b1;
    step(); step();
    chk("R6", "both tied gives no_ref", no_ref, 1);
    chk("R8", "sel frozen under pins", sel_idx, 11);
    los_pin = '0;
    step();
    chk("R6", "pins released", sel_idx, 8);
    los_map = '0;
  endtask

  initial begin
    t_reset();
    t_revert();
    t_hold();
    t_prio();
    t_noref();
    t_los();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule